// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit path of a 10 Mb/s twisted-pair port against a transmitter that never stops. It watches the internal transmit request. If the request stays high for longer than a trip limit, the block forces the transmit output enable low. The output stays off for as long as the request stays high. It comes back only after the request has been low, without a break, for a much longer release period.

Both periods are counted in ticks of a 1 ms enable pulse supplied by the chip. The defaults are 25 ms to trip and 500 ms to release. A sticky status bit reports the event to a management register, and a read strobe clears it. The watchdog works only at 10 Mb/s. At the faster speeds the output enable simply follows the request and the status reads zero.

Top module: `tx_jabber_guard`

## Requirements
- R1: `speedSel` codes are 2'b00 = 10 Mb/s, 2'b01 = 100 Mb/s, 2'b10 = 1000 Mb/s, and 2'b11 is treated like a non-10 speed. At any code other than 2'b00, `txOutEn` equals `txReq` combinationally and `jabStat` is 0, however many ticks arrive.
- R2: At 10 Mb/s, while `txReq` stays high, `txOutEn` follows `txReq` through the first TRIP_MS ticks. The watchdog trips at the clock edge that samples tick number TRIP_MS+1. Any cycle with `txReq` low restarts this count.
- R3: Once tripped, `txOutEn` is 0 whenever `txReq` is high, for any number of ticks, for as long as the request stays high.
- R4: The watchdog releases at the edge that samples the UNJAB_MS-th tick seen while `txReq` is continuously low. If `txReq` goes high during the release count, the count starts again from zero.
- R5: `jabStat` becomes 1 at the trip edge. It stays 1 after release until a one-cycle `statRead` pulse clears it. A `statRead` pulse while the watchdog is still tripped does not clear it.
- R6: A clock edge with `speedSel` not equal to 10 Mb/s clears the trip state, both timers and the status bit. On a return to 10 Mb/s the output is enabled and `jabStat` reads 0.
- R7: After reset, the watchdog is not tripped, `jabStat` is 0, and `txOutEn` follows `txReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle pulse, once per millisecond |
| speedSel | input | 2 | Link speed code (see R1) |
| txReq | input | 1 | Internal transmit request |
| statRead | input | 1 | One-cycle strobe: management read of the status bit |
| txOutEn | output | 1 | Gated transmit output enable |
| jabStat | output | 1 | Sticky jabber status bit |

## Verification
The assertions check, on every cycle, the properties that involve only one or two cycles. These are: the output is gated while tripped with the request high; no release happens while the request stays high; every trip is preceded by a full trip count; the status is sticky while tripped; the state is cleared at non-10 speeds; and the counters stay in range. Only the bench scenarios can show the exact tick on which the watchdog trips and releases. The same holds for the restart of the release count after a short request, the clearing of the trip count by a brief idle, and the read-clear behaviour of the status bit across a whole jabber episode.

// File: rtl/jab_guard_pkg.sv
package jab_guard_pkg;
  localparam logic [1:0] SPEED_10 = 2'b00;

  typedef enum logic {ST_OPEN, ST_JABBED} jabState_t;

  typedef struct packed {
    logic actInc;
    logic actClr;
    logic idleInc;
    logic idleClr;
  } timerCtl_t;
endpackage

// File: rtl/jab_counter.sv
module jab_counter #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic inc,
  input  logic clr,
  output logic atLimit
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == W'(LIMIT));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= W'(LIMIT));
endmodule

// File: rtl/jab_timers.sv
module jab_timers
  import jab_guard_pkg::*;
#(
  parameter int TRIP_MS  = 25,
  parameter int UNJAB_MS = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output logic      actAtLimit,
  output logic      idleAtLimit
);
  jab_counter #(.LIMIT(TRIP_MS)) uActive (
    .clk(clk), .rstN(rstN), .inc(ctl.actInc), .clr(ctl.actClr),
    .atLimit(actAtLimit));

  jab_counter #(.LIMIT(UNJAB_MS - 1)) uIdle (
    .clk(clk), .rstN(rstN), .inc(ctl.idleInc), .clr(ctl.idleClr),
    .atLimit(idleAtLimit));
endmodule

// File: rtl/jab_ctrl.sv
module jab_ctrl
  import jab_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      is10,
  input  logic      tickMs,
  input  logic      txReq,
  input  logic      statRead,
  input  logic      actAtLimit,
  input  logic      idleAtLimit,
  output timerCtl_t ctl,
  output logic      jabbed,
  output logic      statLatch
);
  jabState_t state, stateNxt;
  logic trip, release_;

  assign trip     = is10 && state == ST_OPEN   && txReq  && tickMs && actAtLimit;
  assign release_ = is10 && state == ST_JABBED && !txReq && tickMs && idleAtLimit;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    if (!is10) begin
      ctl.actClr  = 1'b1;
      ctl.idleClr = 1'b1;
      stateNxt    = ST_OPEN;
    end else if (state == ST_OPEN) begin
      ctl.idleClr = 1'b1;
      ctl.actClr  = !txReq || trip;
      ctl.actInc  = txReq && tickMs && !actAtLimit;
      if (trip) stateNxt = ST_JABBED;
    end else begin
      ctl.actClr  = 1'b1;
      ctl.idleClr = txReq || release_;
      ctl.idleInc = !txReq && tickMs && !idleAtLimit;
      if (release_) stateNxt = ST_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OPEN;
      statLatch <= 1'b0;
    end else begin
      state <= stateNxt;
      if (!is10)                            statLatch <= 1'b0;
      else if (trip || state == ST_JABBED)  statLatch <= 1'b1;
      else if (statRead)                    statLatch <= 1'b0;
    end
  end

  assign jabbed = (state == ST_JABBED);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (is10 && jabbed && txReq) |=> jabbed);
  p_trip_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jabbed) |-> $past(actAtLimit && txReq && tickMs));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    jabbed |-> statLatch);
  p_speed_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !is10 |=> (!jabbed && !statLatch));
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
  import jab_guard_pkg::*;
#(
  parameter int TRIP_MS  = 25,
  parameter int UNJAB_MS = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickMs,
  input  logic [1:0] speedSel,
  input  logic       txReq,
  input  logic       statRead,
  output logic       txOutEn,
  output logic       jabStat
);
  timerCtl_t ctl;
  logic is10, jabbed, statLatch, actAtLimit, idleAtLimit;

  assign is10 = (speedSel == SPEED_10);

  jab_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .is10(is10), .tickMs(tickMs), .txReq(txReq),
    .statRead(statRead), .actAtLimit(actAtLimit), .idleAtLimit(idleAtLimit),
    .ctl(ctl), .jabbed(jabbed), .statLatch(statLatch));

  jab_timers #(.TRIP_MS(TRIP_MS), .UNJAB_MS(UNJAB_MS)) uTimers (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .actAtLimit(actAtLimit), .idleAtLimit(idleAtLimit));

  assign txOutEn = txReq && !(is10 && jabbed);
  assign jabStat = is10 && statLatch;

  p_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (is10 && jabbed && txReq) |-> !txOutEn);
  p_fast_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    !is10 |-> (txOutEn == txReq && !jabStat));
endmodule

// File: tb/tx_jabber_guard_test.sv
module tx_jabber_guard_test;
  logic clk = 0, rstN = 0, tickMs = 0, txReq = 0, statRead = 0;
  logic [1:0] speedSel = 2'b00;
  logic txOutEn, jabStat;
  int errors = 0, checks = 0;
  bit done = 0;

  tx_jabber_guard uut (.clk(clk), .rstN(rstN), .tickMs(tickMs),
    .speedSel(speedSel), .txReq(txReq), .statRead(statRead),
    .txOutEn(txOutEn), .jabStat(jabStat));

  always #2 clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickMs = 1; @(negedge clk);
      tickMs = 0; @(negedge clk);
    end
  endtask

  task automatic readStatus();
    statRead = 1; @(negedge clk); statRead = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 enable idle", txOutEn, 1'b0);
    check("R7 status", jabStat, 1'b0);
    txReq = 1; #1;
    check("R7 enable follows", txOutEn, 1'b1);
    txReq = 0; @(negedge clk);
  endtask

  task automatic t_shortBursts();
    txReq = 1; ticks(20);
    txReq = 0; @(negedge clk);
    txReq = 1; ticks(20);
    check("R2 idle clears count", txOutEn, 1'b1);
    check("R2 no status", jabStat, 1'b0);
    txReq = 0; @(negedge clk);
  endtask

  task automatic t_trip();
    txReq = 1; ticks(25);
    check("R2 enabled at limit", txOutEn, 1'b1);
    ticks(1);
    check("R2 tripped past limit", txOutEn, 1'b0);
    check("R5 status set", jabStat, 1'b1);
    ticks(100);
    check("R3 held while requested", txOutEn, 1'b0);
    readStatus();
    check("R5 read while jabbed keeps bit", jabStat, 1'b1);
  endtask

  task automatic t_unjab();
    txReq = 0; ticks(499);
    txReq = 1; #1;
    check("R4 not released early", txOutEn, 1'b0);
    @(negedge clk);
    txReq = 0; ticks(499);
    txReq = 1; #1;
    check("R4 count restarted", txOutEn, 1'b0);
    @(negedge clk);
    txReq = 0; ticks(500);
    txReq = 1; #1;
    check("R4 released", txOutEn, 1'b1);
    check("R5 status sticky after release", jabStat, 1'b1);
    txReq = 0; @(negedge clk);
    readStatus();
    check("R5 read clears", jabStat, 1'b0);
  endtask

  task automatic t_speedChange();
    txReq = 1; ticks(26);
    check("R6 tripped again", txOutEn, 1'b0);
    speedSel = 2'b01; #1;
    check("R1 100M passes request", txOutEn, 1'b1);
    check("R1 100M status zero", jabStat, 1'b0);
    @(negedge clk);
    speedSel = 2'b00; #1;
    check("R6 cleared on return", txOutEn, 1'b1);
    check("R6 status cleared", jabStat, 1'b0);
    txReq = 0; @(negedge clk);
  endtask

  task automatic t_fastSpeeds();
    speedSel = 2'b10; txReq = 1; ticks(60);
    check("R1 1000M never gates", txOutEn, 1'b1);
    check("R1 1000M status zero", jabStat, 1'b0);
    speedSel = 2'b11; ticks(30);
    check("R1 code 3 never gates", txOutEn, 1'b1);
    txReq = 0; speedSel = 2'b00; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    t_reset();
    t_shortBursts();
    t_trip();
    t_unjab();
    t_speedChange();
    t_fastSpeeds();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule